// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the device-side command logic of a byte-wide non-volatile memory model with a 16-bit address bus. It watches single-cycle write strobes on the shared address and data buses and decodes unlock-prefixed command sequences at two fixed key addresses. The commands are byte program, whole-array erase, a one-way write lock on the low boot region, and entry and exit of an identification mode. Program and erase run for a set number of clock cycles. While one of them runs, reads return a polling status word and not stored data.

The storage is a register array of `2**MEM_AW` bytes at addresses `0 .. 2**MEM_AW-1`. The boot region is the lowest `2**BOOT_AW` bytes. Both sizes are parameters, as are the program and erase durations in cycles, so a simulation can keep them short. Reads are registered: `rdata` takes its new value on the clock edge that samples `rd_en` and holds between reads.

Top module: `flash_cmd_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rdata` is 00, `busy` is 0, every array byte reads FF, the boot lock is clear and identification mode is off.
- R2: The four writes AA@5555, 55@2AAA, A0@5555, then D@A store (old & D) at address A. Bits only go from 1 to 0. `busy` is high for exactly PROG_CYCLES cycles, starting at the edge of the fourth write.
- R3: A write whose address or data does not match the next expected step sends the decoder back to idle and leaves the array unchanged. A later command must start again from AA@5555.
- R4: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 set every array byte to FF. `busy` is high for exactly ERASE_CYCLES cycles.
- R5: The same six-write form ending in 40@5555 sets the boot lock. Only reset clears it. It raises no `busy`.
- R6: While the lock is set, a program command to an address below 2**BOOT_AW changes nothing and raises no `busy`, and erase leaves the boot bytes unchanged.
- R7: AA@5555, 55@2AAA, 90@5555 enter identification mode. In that mode, with no operation running, address 0000 reads 1F, 0001 reads 03, 0002 reads the lock on bit 0 with the other bits 0, and every other address reads the array.
- R8: Identification mode is left by a write of data F0 to any address. This works whenever the decoder is not waiting for program data, so the three-write form AA@5555, 55@2AAA, F0@5555 also leaves it.
- R9: While `busy` is high, a read returns bits 5..0 as 0. Bit 6 is 0 on the first read of the operation and flips on each later read. Bit 7 is the inverse of bit 7 of the loaded byte when a program runs and the read address equals the programmed address, and 0 otherwise.
- R10: Writes presented while `busy` is high are ignored: they neither advance the decoder nor alter the array.
- R11: Reset leaves identification mode.
- R12: `rdata` changes only on an edge that samples `rd_en`. Addresses at or above 2**MEM_AW read FF, and program commands to them store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | 16 | Shared read/write address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or status |
| busy | output | 1 | Program or erase in progress |

## Verification
The assertions assume `wr_en` and `rd_en` are never high during reset. They also assume `addr` is valid in every cycle where a strobe is high, since the identification and polling properties compare the sampled address. The stimulus drives every bus signal from the falling clock edge and keeps the strobes low across reset. It issues exactly one strobe per bus cycle, and only reads while a program or erase runs, except in the one case that checks that writes during `busy` are ignored. Write data never contains X, so the sequence decoder always takes a defined path.

// File: rtl/fce_pkg.sv
// Shared constants and types for the flash command interpreter.
// Assumes a 16-bit address bus and byte-wide data.
package fce_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [DATA_W-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DATA_B = 8'h55;
    localparam logic [DATA_W-1:0] OPC_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] OPC_SETUP  = 8'h80;
    localparam logic [DATA_W-1:0] OPC_ERASE  = 8'h10;
    localparam logic [DATA_W-1:0] OPC_LOCK   = 8'h40;
    localparam logic [DATA_W-1:0] OPC_IDENT  = 8'h90;
    localparam logic [DATA_W-1:0] OPC_RESET  = 8'hF0;

    localparam logic [DATA_W-1:0] IDENT_MAKER = 8'h1F;
    localparam logic [DATA_W-1:0] IDENT_PART  = 8'h03;
    localparam logic [DATA_W-1:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PDATA,
        SQ_EKEY0,
        SQ_EKEY1,
        SQ_EKEY2
    } seq_t;
endpackage

// File: rtl/fce_seq_decoder.sv
// Command sequence decoder: tracks the unlock prefix and emits one-cycle
// command pulses. It also owns the identification-mode flag.
// Assumes at most one write per cycle; writes are ignored while busy is high.
module fce_seq_decoder
    import fce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output seq_t              state_o,
    output logic              prog_req,
    output logic              erase_req,
    output logic              lock_req,
    output logic              id_mode
);
    seq_t state;
    logic wr_ok;
    logic hit_a;
    logic hit_b;

    assign wr_ok = wr_en && !busy;
    assign hit_a = (addr == KEY_ADDR_A);
    assign hit_b = (addr == KEY_ADDR_B);

    // Command pulses decoded from the current step and the incoming write.
    always_comb begin
        prog_req  = wr_ok && (state == SQ_PDATA);
        erase_req = wr_ok && (state == SQ_EKEY2) && hit_a && (wdata == OPC_ERASE);
        lock_req  = wr_ok && (state == SQ_EKEY2) && hit_a && (wdata == OPC_LOCK);
    end

    // Step register and identification flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            id_mode <= 1'b0;
        end else if (wr_ok) begin
            if (state != SQ_PDATA && wdata == OPC_RESET) begin
                state   <= SQ_IDLE;
                id_mode <= 1'b0;
            end else begin
                case (state)
                    SQ_IDLE:  state <= (hit_a && wdata == KEY_DATA_A) ? SQ_KEY1 : SQ_IDLE;
                    SQ_KEY1:  state <= (hit_b && wdata == KEY_DATA_B) ? SQ_KEY2 : SQ_IDLE;
                    SQ_KEY2: begin
                        state <= SQ_IDLE;
                        if (hit_a) begin
                            case (wdata)
                                OPC_PROG:  state   <= SQ_PDATA;
                                OPC_SETUP: state   <= SQ_EKEY0;
                                OPC_IDENT: id_mode <= 1'b1;
                                default: ;
                            endcase
                        end
                    end
                    SQ_EKEY0: state <= (hit_a && wdata == KEY_DATA_A) ? SQ_EKEY1 : SQ_IDLE;
                    SQ_EKEY1: state <= (hit_b && wdata == KEY_DATA_B) ? SQ_EKEY2 : SQ_IDLE;
                    default:  state <= SQ_IDLE;
                endcase
            end
        end
    end

    assign state_o = state;
endmodule

// File: rtl/fce_op_timer.sv
// Operation timer: holds busy for a fixed number of cycles after a program
// or erase start, and records which kind of operation is running.
// Assumes start pulses only arrive while idle.
module fce_op_timer #(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy,
    output logic prog_active
);
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] remain;

    // Load the countdown on a start and release busy when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            prog_active <= 1'b0;
            remain      <= '0;
        end else if (!busy) begin
            if (start_prog) begin
                busy        <= 1'b1;
                prog_active <= 1'b1;
                remain      <= CNT_W'(PROG_CYCLES - 1);
            end else if (start_erase) begin
                busy        <= 1'b1;
                prog_active <= 1'b0;
                remain      <= CNT_W'(ERASE_CYCLES - 1);
            end
        end else if (remain == '0) begin
            busy        <= 1'b0;
            prog_active <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/fce_array.sv
// Storage array with AND-only programming, whole-array erase that spares a
// locked boot region, and the one-way lock flag. It also captures the last
// programmed address and byte for polling.
// Assumes command pulses come from the decoder and never arrive while busy.
module fce_array
    import fce_pkg::*;
#(
    parameter int MEM_AW  = 6,
    parameter int BOOT_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              lock_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic              lock,
    output logic              prog_start,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int DEPTH      = 1 << MEM_AW;
    localparam int BOOT_DEPTH = 1 << BOOT_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  erase_mask;
    logic              in_win;
    logic              in_boot;
    logic [MEM_AW-1:0] idx;

    assign idx     = addr[MEM_AW-1:0];
    assign in_win  = (addr[ADDR_W-1:MEM_AW] == '0);
    assign in_boot = (addr[ADDR_W-1:BOOT_AW] == '0);

    // A program is accepted unless it targets the locked boot region.
    assign prog_start = prog_req && !(lock && in_boot);

    // Per-entry erase enable: boot entries follow the lock, others always erase.
    for (genvar g = 0; g < DEPTH; g++) begin : g_mask
        if (g < BOOT_DEPTH) begin : g_boot
            assign erase_mask[g] = !lock;
        end else begin : g_main
            assign erase_mask[g] = 1'b1;
        end
    end

    // Array update: erase sets bytes to FF, program clears bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase_req && erase_mask[i])
                    mem[i] <= ERASED_BYTE;
                else if (prog_start && in_win && int'(idx) == i)
                    mem[i] <= mem[i] & wdata;
            end
        end
    end

    // One-way lock flag; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock <= 1'b0;
        else if (lock_req)
            lock <= 1'b1;
    end

    // Record the target of the most recent accepted program for polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (prog_start) begin
            last_addr <= addr;
            last_data <= wdata;
        end
    end

    assign rd_byte = in_win ? mem[idx] : ERASED_BYTE;
endmodule

// File: rtl/fce_read_path.sv
// Read path: selects polling status, identification codes or array data and
// registers the result on each read strobe.
// Assumes busy and prog_active come from the operation timer.
module fce_read_path
    import fce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              prog_active,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic              id_mode,
    input  logic              lock,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] rdata
);
    logic              toggle;
    logic [DATA_W-1:0] rd_next;
    logic              poll_bit;

    assign poll_bit = prog_active && (addr == last_addr) && !last_data[DATA_W-1];

    // Choose the value a read in this cycle returns.
    always_comb begin
        if (busy)
            rd_next = {poll_bit, toggle, {(DATA_W-2){1'b0}}};
        else if (id_mode && addr == 16'h0000)
            rd_next = IDENT_MAKER;
        else if (id_mode && addr == 16'h0001)
            rd_next = IDENT_PART;
        else if (id_mode && addr == 16'h0002)
            rd_next = {{(DATA_W-1){1'b0}}, lock};
        else
            rd_next = rd_byte;
    end

    // Toggle bit: cleared while idle, flips on each read during an operation.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            toggle <= 1'b0;
        else if (rd_en)
            toggle <= ~toggle;
    end

    // Output register, loaded only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end
endmodule

// File: rtl/flash_cmd_engine.sv
// Top of the flash command interpreter: decoder, timer, array and read path.
// Assumes a synchronous active-low reset and single-cycle bus strobes.
module flash_cmd_engine #(
    parameter int MEM_AW       = 6,
    parameter int BOOT_AW      = 5,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        busy
);
    import fce_pkg::*;

    seq_t              seq_state;
    logic              prog_req;
    logic              erase_req;
    logic              lock_req;
    logic              id_mode;
    logic              lock;
    logic              prog_start;
    logic              prog_active;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_data;
    logic [DATA_W-1:0] rd_byte;

    fce_seq_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .busy      (busy),
        .addr      (addr),
        .wdata     (wdata),
        .state_o   (seq_state),
        .prog_req  (prog_req),
        .erase_req (erase_req),
        .lock_req  (lock_req),
        .id_mode   (id_mode)
    );

    fce_op_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (prog_start),
        .start_erase (erase_req),
        .busy        (busy),
        .prog_active (prog_active)
    );

    fce_array #(
        .MEM_AW  (MEM_AW),
        .BOOT_AW (BOOT_AW)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_req   (prog_req),
        .erase_req  (erase_req),
        .lock_req   (lock_req),
        .addr       (addr),
        .wdata      (wdata),
        .rd_byte    (rd_byte),
        .lock       (lock),
        .prog_start (prog_start),
        .last_addr  (last_addr),
        .last_data  (last_data)
    );

    fce_read_path u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .addr        (addr),
        .busy        (busy),
        .prog_active (prog_active),
        .last_addr   (last_addr),
        .last_data   (last_data),
        .id_mode     (id_mode),
        .lock        (lock),
        .rd_byte     (rd_byte),
        .rdata       (rdata)
    );
endmodule

// File: rtl/fce_checker.sv
// Property checker for the flash command interpreter, bound to the top.
// Assumes strobes are low during reset.
module fce_checker #(
    parameter int ERASE_CYCLES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] addr,
    input logic [7:0]  rdata,
    input logic        busy,
    input logic        id_mode,
    input logic        lock,
    input logic [2:0]  seq_state
);
    localparam int BW = $clog2(ERASE_CYCLES + 1) + 1;

    logic [BW-1:0] busy_run;

    // Count consecutive busy cycles to bound the operation length.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            busy_run <= '0;
        else
            busy_run <= busy_run + 1'b1;
    end

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en |=> $stable(seq_state));

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R7
    id_maker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && id_mode && !busy && addr == 16'h0000 |=> rdata == 8'h1F);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < BW'(ERASE_CYCLES));

    // R11
    id_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !id_mode);

    // R9
    poll_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy |=> rdata[5:0] == 6'b0);
endmodule

bind flash_cmd_engine fce_checker #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .busy      (busy),
    .id_mode   (id_mode),
    .lock      (lock),
    .seq_state (seq_state)
);

// File: tb/flash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb_top;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_engine #(
        .MEM_AW       (6),
        .BOOT_AW      (5),
        .PROG_CYCLES  (PROG_CYC),
        .ERASE_CYCLES (ERASE_CYC)
    ) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    // op: 0 write, 1 read and compare, 2 wait for idle
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] a;
        logic [7:0]  d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 16'h0030, 8'hFF, 4'd1},   // R1 erased after reset
        '{2'd0, 16'h5555, 8'hAA, 4'd2},   // R2 program 5A
        '{2'd0, 16'h2AAA, 8'h55, 4'd2},
        '{2'd0, 16'h5555, 8'hA0, 4'd2},
        '{2'd0, 16'h0030, 8'h5A, 4'd2},
        '{2'd2, 16'h0000, 8'h00, 4'd2},
        '{2'd1, 16'h0030, 8'h5A, 4'd2},
        '{2'd0, 16'h5555, 8'hAA, 4'd2},   // R2 AND-only with 0F
        '{2'd0, 16'h2AAA, 8'h55, 4'd2},
        '{2'd0, 16'h5555, 8'hA0, 4'd2},
        '{2'd0, 16'h0030, 8'h0F, 4'd2},
        '{2'd2, 16'h0000, 8'h00, 4'd2},
        '{2'd1, 16'h0030, 8'h0A, 4'd2},
        '{2'd0, 16'h5555, 8'hAA, 4'd7},   // R7 identification entry
        '{2'd0, 16'h2AAA, 8'h55, 4'd7},
        '{2'd0, 16'h5555, 8'h90, 4'd7},
        '{2'd1, 16'h0000, 8'h1F, 4'd7},
        '{2'd1, 16'h0001, 8'h03, 4'd7},
        '{2'd1, 16'h0002, 8'h00, 4'd7},
        '{2'd1, 16'h0030, 8'h0A, 4'd7},
        '{2'd0, 16'h1234, 8'hF0, 4'd8},   // R8 single-write exit
        '{2'd1, 16'h0000, 8'hFF, 4'd8},
        '{2'd1, 16'h0100, 8'hFF, 4'd12}   // R12 outside the array
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] v;
        do_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic cmd3(input logic [7:0] c);
        do_wr(16'h5555, 8'hAA);
        do_wr(16'h2AAA, 8'h55);
        do_wr(16'h5555, c);
    endtask

    task automatic cmd6(input logic [7:0] c);
        cmd3(8'h80);
        cmd3(c);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        cmd3(8'hA0);
        do_wr(a, d);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v0;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 busy", {7'b0, busy}, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_wr(VEC[i].a, VEC[i].d);
                2'd1: rd_chk($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].a, VEC[i].d);
                default: wait_idle();
            endcase
        end

        // R12 rdata holds without a read strobe
        rd_chk("R12 read", 16'h0030, 8'h0A);
        @(negedge clk); addr = 16'h0000;
        repeat (3) @(negedge clk);
        check("R12 hold", rdata, 8'h0A);

        // R2 busy length of a program
        prog(16'h0031, 8'h3C);
        n = 0;
        // R9 polling reads during program
        rd_chk("R9 poll first", 16'h0031, 8'h80);
        rd_chk("R9 poll second", 16'h0031, 8'hC0);
        rd_chk("R9 poll other addr", 16'h0032, 8'h00);
        wait_idle();
        rd_chk("R9 true data after", 16'h0031, 8'h3C);
        prog(16'h0033, 8'hF0);
        while (busy) begin n++; @(negedge clk); end
        check("R2 program cycles", 8'(n), 8'(PROG_CYC));

        // R3 broken sequence
        do_wr(16'h5555, 8'hAA);
        do_wr(16'h1234, 8'h55);
        do_wr(16'h5555, 8'hA0);
        do_wr(16'h0030, 8'h00);
        check("R3 no busy", {7'b0, busy}, 8'h00);
        rd_chk("R3 array unchanged", 16'h0030, 8'h0A);

        // R12 program outside the array stores nothing
        prog(16'h0140, 8'h00);
        wait_idle();
        rd_chk("R12 outside write", 16'h0140, 8'hFF);

        // R4 erase and its duration
        prog(16'h0005, 8'h11);
        wait_idle();
        cmd6(8'h10);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R4 erase cycles", 8'(n), 8'(ERASE_CYC));
        rd_chk("R4 main erased", 16'h0030, 8'hFF);
        rd_chk("R4 boot erased", 16'h0005, 8'hFF);

        // R5 lockout
        prog(16'h0005, 8'h11);
        wait_idle();
        prog(16'h0030, 8'h22);
        wait_idle();
        cmd6(8'h40);
        check("R5 no busy", {7'b0, busy}, 8'h00);
        cmd3(8'h90);
        rd_chk("R5 lock reported", 16'h0002, 8'h01);
        // R8 three-write exit
        cmd3(8'hF0);
        rd_chk("R8 exit three-write", 16'h0000, 8'hFF);

        // R6 boot program blocked
        prog(16'h0005, 8'h00);
        check("R6 no busy", {7'b0, busy}, 8'h00);
        rd_chk("R6 boot kept", 16'h0005, 8'h11);

        // R6 erase skips boot; R10 writes during busy ignored
        cmd6(8'h10);
        prog(16'h0030, 8'h00);
        wait_idle();
        rd_chk("R6 boot survives erase", 16'h0005, 8'h11);
        rd_chk("R10 busy writes ignored", 16'h0030, 8'hFF);

        // R11 reset leaves identification mode
        cmd3(8'h90);
        rd_chk("R11 id active", 16'h0000, 8'h1F);
        pulse_reset();
        rd_chk("R11 id cleared", 16'h0000, 8'hFF);
        rd_chk("R1 lock cleared", 16'h0005, 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule